// File: doc/BRIEF.md
# Display List Register-Write Engine

The engine is a bus master that turns lists stored in memory into register writes on an internal configuration port. Software places a header in memory. The header describes up to eight bodies of address/data pairs, gives the address of another header, and holds two control flags. Software then writes the header address into the engine. The address is held as an update request until a frame-start pulse arrives while the engine is free. At that point the engine fetches the header, walks the bodies and issues one register write per pair.

When a list is finished, the flags decide what comes next. Auto-start with a different next header chains straight into that header, with no frame start needed. Auto-start with the next header equal to the list's own address forms a continuous loop, which is replayed at every frame start. With auto-start clear the engine stops. The interrupt-enable flag raises a completion pulse, so a chain in which only the last list sets it interrupts once for the whole chain. A second mode skips the header altogether: software gives a body address and a byte size, and at frame start the engine applies that one body and interrupts.

Both data ports use valid/ready. The memory read request is held, with its address stable, until it is accepted. Only one read is in flight at a time, and the response is taken by a ready that the engine raises only while a read is outstanding. The register write is held, with its address and data stable, until the receiver accepts it. The receiver can stall either port for any number of cycles without loss.

Top module: `dlw_engine`

## Requirements
- R1: After reset, rd_req_valid, wr_valid, irq and upd_flag are all 0.
- R2: A cpu_wr pulse stores cpu_addr and cpu_size and sets upd_flag on the next cycle. The flag stays set until a frame_start arrives while the engine is idle or waiting for a frame. At that frame start the flag clears and processing of the stored address begins.
- R3: A header occupies 19 consecutive 32-bit words starting at its base address. Word 0 holds the body count minus one, and only its bits [2:0] are used. For slot i (0 to 7), word 1+2i is the byte size and word 2+2i is the body address. Word 17 is the next-header address. Word 18 is the flags word: bit 0 is auto-start and bit 1 is interrupt enable.
- R4: Slots 0 to count are processed in slot order. A slot holds size/8 entries. Entry e is a register address at body+8e followed by its data at body+8e+4. Each entry produces one write, and writes leave in memory order.
- R5: A slot whose size is below 8 produces no register write, and the engine moves on to the next slot.
- R6: With auto-start set and the next-header address different from the list's own base, the engine fetches and processes the next header without any frame_start.
- R7: irq is a single-cycle pulse after the last write of a list whose interrupt-enable flag is set. A list with that flag clear raises no irq.
- R8: With both flags set and the next header equal to the list's own base, the engine replays the list at each later frame_start and issues no writes between replays.
- R9: An update written while a list runs does not disturb that list. Every body of the list completes, and the new address is taken only at the first frame_start after the list has finished.
- R10: With auto-start clear, the engine goes idle after the list. A frame_start while idle with no pending update causes no memory read and no write.
- R11: With hdrless_mode high, the pending update holds a body address (cpu_addr) and byte size (cpu_size). At frame_start the engine clears upd_flag, writes that body's entries and pulses irq once, then goes idle.
- R12: Only one memory read is outstanding at a time. rd_req_valid with its address, and wr_valid with its address and data, are held stable until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdrless_mode | input | 1 | 1: the update holds a single body; 0: the update holds a header address |
| cpu_wr | input | 1 | Strobe that stores a new update |
| cpu_addr | input | 32 | Header address, or body address in hdrless_mode |
| cpu_size | input | 32 | Body byte size, used only in hdrless_mode |
| upd_flag | output | 1 | An update is stored and not yet taken |
| frame_start | input | 1 | Frame-start pulse |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Byte address of the 32-bit word to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine takes read data |
| rd_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 32 | Register address |
| wr_data | output | 32 | Register data |
| irq | output | 1 | List-completion pulse |

## Verification
The hardest case to reach is an update that lands while a continuous loop is part-way through its bodies. It must neither cut the running list short nor start before the next frame start. The bench commits the looping header and fires the frame start. It then writes the new address a few cycles into the replay, while the memory and the write port keep applying back-pressure. It checks that the loop's writes all appear, that upd_flag stays high through an idle stretch, and that the new list starts only at the next frame start. Chains, zero-size slots and a header whose count word carries junk in its upper bits are laid out in a bench memory image. The expected writes are predicted from that image.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_SEL, S_ENT_A, S_ENT_D, S_WR, S_DONE, S_WAITF
  } dlw_state_e;
  localparam int FLAG_AUTO = 0;
  localparam int FLAG_IRQ  = 1;
endpackage

// File: rtl/dlw_upd_latch.sv
module dlw_upd_latch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] size_i,
  input  logic          take_i,
  output logic          flag_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] size_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      addr_o <= '0;
      size_o <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      addr_o <= addr_i;
      size_o <= size_i;
    end else if (take_i) begin
      flag_o <= 1'b0;
    end
  end

  // R2: a write always leaves the flag raised
  a_r2_upd_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R2: the flag only drops when the engine takes the update
  a_r2_upd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !set_i && !take_i) |=> flag_o);
endmodule

// File: rtl/dlw_slot_table.sv
module dlw_slot_table #(
  parameter int AW    = 32,
  parameter int NSLOT = 8,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] widx,
  input  logic          wsel_addr,
  input  logic [AW-1:0] wdata,
  input  logic          ld0,
  input  logic [AW-1:0] ld0_size,
  input  logic [AW-1:0] ld0_addr,
  input  logic [SW-1:0] ridx,
  output logic [AW-1:0] rsize,
  output logic [AW-1:0] raddr
);
  logic [AW-1:0] sz [NSLOT];
  logic [AW-1:0] ad [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sz[i] <= '0;
        ad[i] <= '0;
      end else if (ld0 && i == 0) begin
        sz[i] <= ld0_size;
        ad[i] <= ld0_addr;
      end else if (we && widx == SW'(i)) begin
        if (wsel_addr) ad[i] <= wdata;
        else           sz[i] <= wdata;
      end
    end
  end

  assign rsize = sz[ridx];
  assign raddr = ad[ridx];
endmodule

// File: rtl/dlw_engine.sv
module dlw_engine #(
  parameter int AW    = 32,
  parameter int NSLOT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdrless_mode,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] cpu_size,
  output logic          upd_flag,
  input  logic          frame_start,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [AW-1:0] rd_rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_data,
  output logic          irq
);
  import dlw_pkg::*;

  localparam int SW        = $clog2(NSLOT);
  localparam int HDR_WORDS = 2 * NSLOT + 3;
  localparam int HW_W      = $clog2(HDR_WORDS);
  localparam int NEXT_IDX  = 2 * NSLOT + 1;
  localparam int FLAG_IDX  = 2 * NSLOT + 2;

  dlw_state_e      st;
  logic            rd_wait;
  logic [AW-1:0]   cur_hdr, next_hdr, body_base;
  logic [HW_W-1:0] hw_idx;
  logic [SW-1:0]   cnt;
  logic [SW:0]     slot_idx;
  logic [1:0]      flags;
  logic [AW-1:0]   ent_idx, ent_cnt;
  logic [AW-1:0]   wa_q, wd_q;
  logic            irq_q;

  logic [AW-1:0]   upd_addr, upd_size, rsize, raddr;
  logic            take, rd_active, req_fire, rsp_fire;
  logic            slot_we, ld0;

  assign take = frame_start && upd_flag && (st == S_IDLE || st == S_WAITF);
  assign ld0  = take && hdrless_mode;

  dlw_upd_latch #(.AW(AW)) u_upd (
    .clk(clk), .rst_n(rst_n), .set_i(cpu_wr), .addr_i(cpu_addr),
    .size_i(cpu_size), .take_i(take), .flag_o(upd_flag),
    .addr_o(upd_addr), .size_o(upd_size)
  );

  assign slot_we = (st == S_HDR) && rsp_fire &&
                   (hw_idx >= HW_W'(1)) && (hw_idx <= HW_W'(2 * NSLOT));

  dlw_slot_table #(.AW(AW), .NSLOT(NSLOT)) u_slots (
    .clk(clk), .rst_n(rst_n), .we(slot_we),
    .widx(SW'((hw_idx - 1'b1) >> 1)), .wsel_addr(~hw_idx[0]),
    .wdata(rd_rsp_data), .ld0(ld0), .ld0_size(upd_size),
    .ld0_addr(upd_addr), .ridx(slot_idx[SW-1:0]),
    .rsize(rsize), .raddr(raddr)
  );

  assign rd_active    = (st == S_HDR) || (st == S_ENT_A) || (st == S_ENT_D);
  assign rd_req_valid = rd_active && !rd_wait;
  assign rd_rsp_ready = rd_wait;
  assign req_fire     = rd_req_valid && rd_req_ready;
  assign rsp_fire     = rd_rsp_valid && rd_rsp_ready;

  always_comb begin
    case (st)
      S_HDR:   rd_req_addr = cur_hdr + AW'({hw_idx, 2'b00});
      S_ENT_A: rd_req_addr = body_base + AW'({ent_idx, 3'b000});
      S_ENT_D: rd_req_addr = body_base + AW'({ent_idx, 3'b000}) + AW'(4);
      default: rd_req_addr = '0;
    endcase
  end

  assign wr_valid = (st == S_WR);
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_wait   <= 1'b0;
      cur_hdr   <= '0;
      next_hdr  <= '0;
      body_base <= '0;
      hw_idx    <= '0;
      cnt       <= '0;
      slot_idx  <= '0;
      flags     <= '0;
      ent_idx   <= '0;
      ent_cnt   <= '0;
      wa_q      <= '0;
      wd_q      <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (req_fire) rd_wait <= 1'b1;
      if (rsp_fire) rd_wait <= 1'b0;
      case (st)
        S_IDLE, S_WAITF: begin
          if (take && hdrless_mode) begin
            cnt      <= '0;
            flags    <= 2'b10;
            slot_idx <= '0;
            st       <= S_SEL;
          end else if (take) begin
            cur_hdr <= upd_addr;
            hw_idx  <= '0;
            st      <= S_HDR;
          end else if (frame_start && st == S_WAITF) begin
            hw_idx <= '0;
            st     <= S_HDR;
          end
        end
        S_HDR: if (rsp_fire) begin
          if (hw_idx == '0) cnt <= rd_rsp_data[SW-1:0];
          if (hw_idx == HW_W'(NEXT_IDX)) next_hdr <= rd_rsp_data;
          if (hw_idx == HW_W'(FLAG_IDX)) begin
            flags    <= rd_rsp_data[1:0];
            slot_idx <= '0;
            st       <= S_SEL;
          end
          hw_idx <= hw_idx + 1'b1;
        end
        S_SEL: begin
          if (slot_idx > {1'b0, cnt}) begin
            st <= S_DONE;
          end else if ((rsize >> 3) == '0) begin
            slot_idx <= slot_idx + 1'b1;
          end else begin
            body_base <= raddr;
            ent_cnt   <= rsize >> 3;
            ent_idx   <= '0;
            st        <= S_ENT_A;
          end
        end
        S_ENT_A: if (rsp_fire) begin
          wa_q <= rd_rsp_data;
          st   <= S_ENT_D;
        end
        S_ENT_D: if (rsp_fire) begin
          wd_q <= rd_rsp_data;
          st   <= S_WR;
        end
        S_WR: if (wr_ready) begin
          if (ent_idx + 1'b1 == ent_cnt) begin
            slot_idx <= slot_idx + 1'b1;
            st       <= S_SEL;
          end else begin
            ent_idx <= ent_idx + 1'b1;
            st      <= S_ENT_A;
          end
        end
        S_DONE: begin
          irq_q <= flags[FLAG_IRQ];
          if (!flags[FLAG_AUTO]) begin
            st <= S_IDLE;
          end else if (next_hdr == cur_hdr) begin
            st <= S_WAITF;
          end else begin
            cur_hdr <= next_hdr;
            hw_idx  <= '0;
            st      <= S_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r4_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(rd_rsp_valid && rd_rsp_ready));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!wr_valid && !rd_req_valid));
endmodule

// File: tb/dlw_engine_tb.sv
module dlw_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdrless_mode = 1'b0;
  logic cpu_wr = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_size = '0;
  logic upd_flag, frame_start = 1'b0;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dlw_engine u_dut (
    .clk(clk), .rst_n(rst_n), .hdrless_mode(hdrless_mode), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .upd_flag(upd_flag),
    .frame_start(frame_start), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  logic [31:0] mem [1024];
  logic [63:0] expq [$];
  int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void put(input int a, input logic [31:0] d);
    mem[a >> 2] = d;
  endfunction

  function automatic void mk_body(input int a, input int n, input int tag);
    for (int e = 0; e < n; e++) begin
      put(a + 8 * e, 32'h0100_0000 + tag * 256 + e * 4);
      put(a + 8 * e + 4, 32'hD000_0000 + tag * 65536 + e);
    end
  endfunction

  function automatic void mk_hdr(input int b, input logic [31:0] cw,
                                 input logic [31:0] nxt, input logic [31:0] fl);
    put(b, cw);
    put(b + 68, nxt);
    put(b + 72, fl);
  endfunction

  function automatic void set_slot(input int b, input int i, input int sz, input int a);
    put(b + 4 + 8 * i, sz);
    put(b + 8 + 8 * i, a);
  endfunction

  // expected writes for one body (R4)
  function automatic void exp_body(input int a, input int sz);
    for (int e = 0; e < sz / 8; e++)
      expq.push_back({mem[(a + 8 * e) >> 2], mem[(a + 8 * e + 4) >> 2]});
  endfunction

  // expected writes for a header (R3, R4, R5)
  function automatic void exp_list(input int b);
    int n = int'(mem[b >> 2] & 32'h7);
    for (int i = 0; i <= n; i++)
      exp_body(int'(mem[(b + 8 + 8 * i) >> 2]), int'(mem[(b + 4 + 8 * i) >> 2]));
  endfunction

  // memory responder and write sink with back-pressure
  initial begin
    bit busy = 1'b0;
    int dly = 0;
    logic [31:0] ra = '0;
    forever begin
      @(posedge clk);
      cyc++;
      if (busy) begin
        if (rd_rsp_valid && rd_rsp_ready) begin
          rd_rsp_valid <= 1'b0;
          busy = 1'b0;
        end else if (!rd_rsp_valid) begin
          if (dly == 0) begin
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= mem[ra[11:2]];
          end else dly--;
        end
      end else if (rd_req_valid && rd_req_ready) begin
        busy = 1'b1;
        ra   = rd_req_addr;
        dly  = cyc % 3;
      end
      rd_req_ready <= (cyc % 4) != 1;
      wr_ready     <= (cyc % 5) != 2;
    end
  end

  // per-clock comparison against the predicted write stream
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && wr_valid && wr_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4/R10 unexpected write", {wr_addr, wr_data}, 64'h0);
        end else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk({wr_addr, wr_data} == e, "R4 write order", {wr_addr, wr_data}, e);
        end
      end
      if (rst_n && irq) irq_cnt++;
    end
  end

  task automatic cpu_set(input int a, input int sz);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_size = sz;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic fs();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (expq.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(expq.size() == 0, req, expq.size(), 0);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base_irq;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    // H0: single-shot, two bodies
    mk_hdr(32'h000, 32'd1, 32'h0, 32'h2);
    set_slot(32'h000, 0, 24, 32'h400); mk_body(32'h400, 3, 1);
    set_slot(32'h000, 1, 16, 32'h440); mk_body(32'h440, 2, 2);
    // H1: junk above count, zero-size middle slot
    mk_hdr(32'h100, 32'hFFFF_FFFA, 32'h0, 32'h2);
    set_slot(32'h100, 0, 8, 32'h480);  mk_body(32'h480, 1, 3);
    set_slot(32'h100, 1, 0, 32'h4C0);  mk_body(32'h4C0, 2, 4);
    set_slot(32'h100, 2, 16, 32'h500); mk_body(32'h500, 2, 5);
    // H2 -> H3 chain
    mk_hdr(32'h200, 32'd0, 32'h300, 32'h1);
    set_slot(32'h200, 0, 8, 32'h540);  mk_body(32'h540, 1, 6);
    mk_hdr(32'h300, 32'd0, 32'h0, 32'h2);
    set_slot(32'h300, 0, 16, 32'h580); mk_body(32'h580, 2, 7);
    // H4: all eight slots
    mk_hdr(32'h380, 32'd7, 32'h0, 32'h2);
    for (int i = 0; i < 8; i++) begin
      set_slot(32'h380, i, 8, 32'h600 + 16 * i);
      mk_body(32'h600 + 16 * i, 1, 8 + i);
    end
    // H5: continuous loop
    mk_hdr(32'h080, 32'd0, 32'h080, 32'h3);
    set_slot(32'h080, 0, 24, 32'h800); mk_body(32'h800, 3, 20);
    mk_body(32'h900, 3, 30);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!rd_req_valid && !wr_valid && !irq && !upd_flag, "R1 reset outputs",
        {rd_req_valid, wr_valid, irq, upd_flag}, 0);

    // R10: frame start with nothing pending
    fs(); repeat (30) @(negedge clk);
    chk(!rd_req_valid && irq_cnt == 0, "R10 idle frame start", irq_cnt, 0);

    // R2, R3, R4, R7: single-shot list
    cpu_set(32'h000, 0);
    chk(upd_flag, "R2 flag set", upd_flag, 1);
    repeat (10) @(negedge clk);
    chk(upd_flag && !rd_req_valid, "R2 held until frame start", upd_flag, 1);
    exp_list(32'h000);
    fs();
    wait_done("R4 single-shot writes");
    chk(!upd_flag, "R2 flag cleared", upd_flag, 0);
    chk(irq_cnt == 1, "R7 irq count", irq_cnt, 1);
    fs(); repeat (40) @(negedge clk);
    chk(irq_cnt == 1, "R10 stays idle", irq_cnt, 1);

    // R5, R3: zero-size slot, junk count bits
    cpu_set(32'h100, 0);
    exp_list(32'h100);
    fs();
    wait_done("R5 zero-size skip");
    chk(irq_cnt == 2, "R5 irq after skip", irq_cnt, 2);

    // R6, R7: chain needs one frame start, one irq
    cpu_set(32'h200, 0);
    exp_list(32'h200); exp_list(32'h300);
    fs();
    wait_done("R6 chain writes");
    chk(irq_cnt == 3, "R7 one irq per chain", irq_cnt, 3);

    // R4: eight bodies
    cpu_set(32'h380, 0);
    exp_list(32'h380);
    fs();
    wait_done("R4 eight bodies");
    chk(irq_cnt == 4, "R4 irq eight bodies", irq_cnt, 4);

    // R8: continuous loop
    cpu_set(32'h080, 0);
    exp_list(32'h080);
    fs();
    wait_done("R8 first pass");
    chk(irq_cnt == 5, "R8 irq first pass", irq_cnt, 5);
    repeat (40) @(negedge clk);
    chk(irq_cnt == 5, "R8 no replay without frame", irq_cnt, 5);
    exp_list(32'h080);
    fs();
    // R9: update lands mid-list
    repeat (6) @(negedge clk);
    cpu_set(32'h000, 0);
    wait_done("R9 running list completes");
    chk(irq_cnt == 6 && upd_flag, "R9 update still pending",
        {irq_cnt, upd_flag}, {32'd6, 1'b1});
    repeat (30) @(negedge clk);
    chk(upd_flag, "R9 not taken without frame", upd_flag, 1);
    exp_list(32'h000);
    fs();
    wait_done("R9 new list after frame");
    chk(!upd_flag && irq_cnt == 7, "R9 taken", {irq_cnt, upd_flag}, {32'd7, 1'b0});
    fs(); repeat (40) @(negedge clk);
    chk(irq_cnt == 7, "R10 loop replaced", irq_cnt, 7);

    // R11: headerless body
    hdrless_mode = 1'b1;
    cpu_set(32'h900, 24);
    exp_body(32'h900, 24);
    fs();
    wait_done("R11 headerless writes");
    chk(!upd_flag && irq_cnt == 8, "R11 flag and irq", {irq_cnt, upd_flag}, {32'd8, 1'b0});

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule